// File: doc/BRIEF.md
# DMA Channel Transfer Count Unit

This block keeps the transfer count for one DMA channel. Software loads the number of transfers still to be done through a 32-bit register port while the channel is idle. Each time the transfer engine reports a finished transfer on an active channel, the count drops by one. When the count reaches zero through such a decrement, the block pulses a terminal-count output that tells the engine to stop the channel. It also raises a sticky interrupt request, which stays up until software clears it.

A loaded count of zero turns the count function off. Transfers then run without limit, the count stays at zero, and no terminal event or interrupt ever comes from the count. Software may read the count at any time. The read returns a registered value in one access, so a decrement cannot split the value.

The register port has a one-bit address. Address 0 is the count register: bits 23..0 hold the count and bits 31..24 always read as zero. Address 1 is the status register: bit 0 is the interrupt flag, and writing a one to that bit clears it.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset the count is 0, termCount is 0 and irqReq is 0. A read of address 0 returns 0.
- R2: A read of address 0 returns the count in bits 23..0 and zeros in bits 31..24. A read of address 1 returns the interrupt flag in bit 0 and zeros elsewhere. Reads are combinational from registered state.
- R3: A write to address 0 while chanActive is 0 loads regWrData[23..0] into the count, visible on the next cycle. Bits 31..24 of the write data have no effect.
- R4: A write to address 0 while chanActive is 1 is ignored, and the count keeps its value.
- R5: When chanActive and xferDone are both 1 and the count is nonzero, the count decreases by exactly one on that clock edge.
- R6: xferDone while chanActive is 0 leaves the count unchanged.
- R7: A decrement from 1 to 0 drives termCount high on the cycle after that edge, for exactly one cycle.
- R8: The same decrement sets the interrupt flag, driven on irqReq in the same cycle that termCount rises. The flag stays set until a write to address 1 with bit 0 set. A write to address 1 with bit 0 clear has no effect on the flag.
- R9: With a count of 0, strobes leave the count at 0 and produce no termCount and no interrupt.
- R10: The maximum count 0xFFFFFF loads exactly and decrements to 0xFFFFFE.
- R11: If the flag is set and cleared on the same edge, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 1 | Register select: 0 count, 1 status |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| chanActive | input | 1 | Channel is transferring |
| xferDone | input | 1 | One transfer completed this cycle |
| termCount | output | 1 | One-cycle pulse when the count runs out |
| irqReq | output | 1 | Sticky transfer-end interrupt request |

## Verification
Every load value from 1 to 40 is counted down to zero. The gaps between strobes vary, which separates decrements that depend on the strobe from decrements that depend on the cycle. Each step checks the remaining count and whether termCount and irqReq are present, so an end event that fires one step early or late shows up at once.

Separate patterns cover the other cases:
- a zero load with many strobes, which separates unlimited mode from a wrapped counter;
- the maximum value;
- strobes on an idle channel and writes on an active channel, both of which must not move the count;
- a write of zero to the status register, which must leave the flag alone, and a write of one, which must clear it;
- a flag set and clear on the same edge, which must keep the flag set.

// File: rtl/xcnt_pkg.sv
package xcnt_pkg;
  typedef struct packed {
    logic load;    // take new count from write data
    logic dec;     // decrement count by one
  } cntStrobes_t;
endpackage

// File: rtl/xcnt_datapath.sv
module xcnt_datapath #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  xcnt_pkg::cntStrobes_t     strb,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      rdSel,
  input  logic                      flag,
  input  logic                      chanActive,
  input  logic                      xferDone,
  output logic                      cntZero,
  output logic                      cntOne,
  output logic [DATA_W-1:0]         rdData
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (strb.load) count <= wrData[CNT_W-1:0];
    else if (strb.dec)  count <= count - 1'b1;
  end

  assign cntZero = (count == '0);
  assign cntOne  = (count == CNT_W'(1));

  always_comb begin
    if (rdSel) rdData = {{(DATA_W-1){1'b0}}, flag};
    else       rdData = {{PAD_W{1'b0}}, count};
  end

  // R4: an active channel without a strobe never changes the count
  p_hold_when_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && !xferDone) |=> $stable(count));

  // R5: a strobe on an active channel with a nonzero count decrements by one
  p_dec_by_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && xferDone && count != '0) |=> (count == $past(count) - 1'b1));

  // R6: strobes on an idle channel do not decrement
  p_idle_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!chanActive && !strb.load) |=> $stable(count));

  // R9: a zero count stays zero while the channel is active
  p_zero_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && count == '0) |=> (count == '0));
endmodule

// File: rtl/xcnt_control.sv
module xcnt_control #(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  chanActive,
  input  logic                  xferDone,
  input  logic                  cntZero,
  input  logic                  cntOne,
  output xcnt_pkg::cntStrobes_t strb,
  output logic                  flag,
  output logic                  termCount
);
  logic hitEnd;
  logic clrReq;

  always_comb begin
    strb.load = regWrEn && !regAddr && !chanActive;
    strb.dec  = chanActive && xferDone && !cntZero;
  end

  assign hitEnd = strb.dec && cntOne;
  assign clrReq = regWrEn && regAddr && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag      <= 1'b0;
      termCount <= 1'b0;
    end else begin
      termCount <= hitEnd;
      if (hitEnd)      flag <= 1'b1;
      else if (clrReq) flag <= 1'b0;
    end
  end

  // R7: the end pulse lasts exactly one cycle
  p_term_one_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    termCount |=> !termCount);

  // R8: the interrupt is up whenever the end pulse is
  p_irq_with_term_r8: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> flag);

  // R8: the flag falls only through a clearing write
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> $past(clrReq));

  // R9: a zero count never produces an end pulse
  p_no_term_at_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    cntZero |=> !termCount);

  // R4: the count never loads while the channel is active
  p_no_load_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    chanActive |-> !strb.load);
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              chanActive,
  input  logic              xferDone,
  output logic              termCount,
  output logic              irqReq
);
  xcnt_pkg::cntStrobes_t strb;
  logic cntZero;
  logic cntOne;
  logic flag;

  xcnt_control #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .chanActive(chanActive), .xferDone(xferDone),
    .cntZero(cntZero), .cntOne(cntOne), .strb(strb), .flag(flag),
    .termCount(termCount)
  );

  xcnt_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .rdSel(regAddr), .flag(flag), .chanActive(chanActive),
    .xferDone(xferDone), .cntZero(cntZero), .cntOne(cntOne),
    .rdData(regRdData)
  );

  assign irqReq = flag;
endmodule

// File: tb/test_dma_xfer_count.sv
module test_dma_xfer_count;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regAddr = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        chanActive = 1'b0;
  logic        xferDone = 1'b0;
  logic        termCount;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dma_xfer_count i_dma_xfer_count (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .chanActive(chanActive),
    .xferDone(xferDone), .termCount(termCount), .irqReq(irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic a, output logic [31:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic wrReg(input logic a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; regAddr = 1'b0;
  endtask

  task automatic strobe();
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic checkCount(input string req, input logic [31:0] exp);
    logic [31:0] v;
    readReg(1'b0, v);
    chk(req, v, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkCount("R1 count", 32'h0);
    chk("R1 termCount", {31'b0, termCount}, 32'h0);
    chk("R1 irqReq", {31'b0, irqReq}, 32'h0);

    // R2/R3: high bits ignored on write, read as zero
    wrReg(1'b0, 32'hAB00_0123);
    checkCount("R2 R3 upper bits", 32'h0000_0123);
    readReg(1'b1, v);
    chk("R2 status read", v, 32'h0);

    // R6: idle strobes leave count
    for (int i = 0; i < 4; i++) strobe();
    checkCount("R6 idle strobes", 32'h0000_0123);

    // R4: write while active ignored
    chanActive = 1'b1;
    wrReg(1'b0, 32'h0000_0055);
    checkCount("R4 blocked write", 32'h0000_0123);
    chanActive = 1'b0;
    @(negedge clk);

    // R5 R7 R8 sweep over load values 1..40
    for (int n = 1; n <= 40; n++) begin
      wrReg(1'b0, 32'(n));
      checkCount("R3 load", 32'(n));
      chanActive = 1'b1;
      for (int k = 1; k <= n; k++) begin
        strobe();
        checkCount("R5 decrement", 32'(n - k));
        chk("R7 termCount", {31'b0, termCount}, {31'b0, (k == n)});
        chk("R8 irqReq", {31'b0, irqReq}, {31'b0, (k == n)});
        for (int g = 0; g < (k % 3); g++) @(negedge clk);
      end
      @(negedge clk);
      chk("R7 pulse width", {31'b0, termCount}, 32'h0);
      strobe();
      checkCount("R9 stays zero after end", 32'h0);
      chk("R9 no second term", {31'b0, termCount}, 32'h0);
      chanActive = 1'b0;
      wrReg(1'b1, 32'h0000_0000);
      chk("R8 write zero keeps flag", {31'b0, irqReq}, 32'h1);
      readReg(1'b1, v);
      chk("R2 status flag", v, 32'h1);
      wrReg(1'b1, 32'h0000_0001);
      chk("R8 w1c clears", {31'b0, irqReq}, 32'h0);
    end

    // R9: zero load is unlimited
    wrReg(1'b0, 32'h0);
    chanActive = 1'b1;
    for (int i = 0; i < 50; i++) begin
      strobe();
      chk("R9 zero mode term", {31'b0, termCount}, 32'h0);
    end
    checkCount("R9 zero mode count", 32'h0);
    chk("R9 zero mode irq", {31'b0, irqReq}, 32'h0);
    chanActive = 1'b0;

    // R10: maximum value
    wrReg(1'b0, 32'h00FF_FFFF);
    checkCount("R10 max load", 32'h00FF_FFFF);
    chanActive = 1'b1;
    strobe();
    checkCount("R10 max dec", 32'h00FF_FFFE);
    chanActive = 1'b0;

    // R11: set beats clear on the same edge
    wrReg(1'b0, 32'h1);
    chanActive = 1'b1;
    xferDone = 1'b1;
    wrReg(1'b1, 32'h1);
    xferDone = 1'b0;
    chk("R11 set wins", {31'b0, irqReq}, 32'h1);
    chk("R11 term", {31'b0, termCount}, 32'h1);
    chanActive = 1'b0;
    wrReg(1'b1, 32'h1);
    chk("R8 final clear", {31'b0, irqReq}, 32'h0);

    // R1: reset mid-run restores reset state
    wrReg(1'b0, 32'h77);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkCount("R1 reset again", 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule